// File: doc/BRIEF.md
# PS/2 Device-Side Transmit Engine

This block is the sending half of a PS/2 device. Software places up to sixteen bytes into a buffer of four 32-bit words, picks how many of them go out, and enables the engine. The engine then sends the bytes one by one, lowest index first, as 11-bit PS/2 frames. It generates every bus clock pulse itself from a divided system clock. Both bus lines are open-drain. The block only ever pulls a line low or lets it go. It reads the lines back through synchronisers.

Before each clock pulse the engine checks whether the host is holding the clock line low. If it is, the frame is dropped and the same byte is sent again once both lines are back high. A clear command stops a transfer at once and rewinds the byte pointer. It leaves the stored words untouched, so the same data can be sent again by writing any one word. A transmit-done flag is raised at the end of every stop bit. It is cleared by writing 1, and it reaches the interrupt output only when the interrupt enable is set.

Top module: `ps2_dev_tx`

## Requirements
- R1: After reset, both line drivers are released, busy is 0, empty is 1, the byte index is 0, and both the done flag and the interrupt are 0.
- R2: Write port decode (defaults).
  - Select values 0 to 3 write data words 0 to 3.
  - Select 4 writes the control fields: bit 0 is enable, bit 1 is the interrupt enable, bits 5:2 are the depth, and bit 6 is a clear command that is not stored.
  - Select 5 bit 0 is a write-1-to-clear of the done flag.
- R3: A data-word write while enabled clears empty in the next cycle. A frame then starts only while both synchronised lines are high. A data-word write while disabled leaves empty at 1 and sends nothing.
- R4: Each frame carries, in this order, a start bit of 0, eight data bits LSB first, an odd-parity bit and a stop bit of 1. The engine holds the clock line low for HALF_CYC cycles and releases it for HALF_CYC cycles per bit. The data line changes only while the clock line is released.
- R5: Byte index i is taken from bits 8*(i mod 4)+7 to 8*(i mod 4) of data word i/4.
- R6: A depth value N sends N+1 bytes. The byte index advances by one after every completed frame. After the last byte, empty returns to 1 and the index returns to 0.
- R7: Busy is 1 from the cycle after a frame starts until the frame ends, is aborted, or is cleared.
- R8: The done flag is set when a stop bit ends and is cleared by writing 1. The interrupt output equals the done flag gated by the interrupt enable.
- R9: A clear command releases both lines and drops busy in the next cycle. It also sets empty and resets the index to 0. The stored words are kept, so a later data write resends from index 0 with the old contents.
- R10: If the synchronised clock line is low at the end of a released-clock half period, the frame is aborted, the lines are released, and the index is kept. The byte is sent again, complete, after the host lets go.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write target select |
| wr_data | input | 32 | Write data |
| ps2_clk_in | input | 1 | Bus clock line level |
| ps2_dat_in | input | 1 | Bus data line level |
| ps2_clk_oe | output | 1 | 1 pulls the bus clock line low |
| ps2_dat_oe | output | 1 | 1 pulls the bus data line low |
| tx_busy | output | 1 | Frame in progress |
| tx_empty | output | 1 | No bytes left to send |
| tx_byte_idx | output | 4 | Index of the next byte to send |
| tx_done_flag | output | 1 | Stop-bit-sent flag |
| tx_irq | output | 1 | Interrupt request |

## Verification
The assertions assume the depth field is rewritten only while the engine is idle with the index at 0, or together with a clear. They also assume the host pulls the clock low only while the engine has it released. The byte-index bound and the data-stability check rely on this. The stimulus programs the depth only between transfers or with the clear bit set. It asserts its clock hold only just after observing the engine release the clock line. It never drives the data line while a frame is in flight.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_HIGH,
    PH_LOW
  } phase_t;

  localparam int FRAME_BITS = 11;

  // Odd parity: the returned bit makes the count of ones in {p,d} odd.
  function automatic logic odd_parity(input logic [7:0] d);
    return ~(^d);
  endfunction

  // Frame as sent, bit 0 first: start, data LSB first, parity, stop.
  function automatic logic [FRAME_BITS-1:0] build_frame(input logic [7:0] d);
    return {1'b1, odd_parity(d), d, 1'b0};
  endfunction

  // Byte lane selection inside a 32-bit word.
  function automatic logic [7:0] lane_of(input logic [31:0] w, input logic [1:0] lane);
    return w[{lane, 3'b000} +: 8];
  endfunction

endpackage

// File: rtl/ps2tx_sync.sv
module ps2tx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ps2tx_divider.sv
module ps2tx_divider #(
  parameter int HALF_CYC = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic half_tick
);
  localparam int CW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           cnt <= '0;
    else if (!run)        cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;

  assign half_tick = run && (cnt == LAST);

  a_r4_tick_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |-> $past(run))
    else $error("half tick without a running divider");
endmodule

// File: rtl/ps2tx_buf.sv
module ps2tx_buf #(
  parameter int WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_word,
  input  logic [$clog2(WORDS)-1:0]     wr_word_sel,
  input  logic [31:0]                  wr_data,
  input  logic [$clog2(WORDS*4)-1:0]   rd_idx,
  output logic [7:0]                   rd_byte
);
  import ps2tx_pkg::*;

  localparam int WSEL_W = $clog2(WORDS);
  localparam int IDX_W  = $clog2(WORDS * 4);

  logic [31:0] words [WORDS];

  generate
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) words[w] <= '0;
        else if (wr_word && (wr_word_sel == WSEL_W'(w))) words[w] <= wr_data;
    end
  endgenerate

  assign rd_byte = lane_of(words[rd_idx[IDX_W-1:2]], rd_idx[1:0]);
endmodule

// File: rtl/ps2tx_frame.sv
module ps2tx_frame #(
  parameter int HALF_CYC = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] byte_in,
  input  logic       kill,
  input  logic       clk_line_hi,
  output logic       clk_low,
  output logic       dat_low,
  output logic       busy,
  output logic       frame_done,
  output logic       frame_abort
);
  import ps2tx_pkg::*;

  localparam logic [3:0] LAST_BIT = 4'(FRAME_BITS - 1);

  phase_t                  phase;
  logic [FRAME_BITS-1:0]   frm;
  logic [3:0]              bitn;
  logic                    half_tick;
  logic [FRAME_BITS-1:0]   frm_new;

  assign frm_new = build_frame(byte_in);
  assign busy    = (phase != PH_IDLE);

  ps2tx_divider #(.HALF_CYC(HALF_CYC)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .half_tick(half_tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      frm         <= '1;
      bitn        <= '0;
      clk_low     <= 1'b0;
      dat_low     <= 1'b0;
      frame_done  <= 1'b0;
      frame_abort <= 1'b0;
    end else begin
      frame_done  <= 1'b0;
      frame_abort <= 1'b0;
      if (kill) begin
        phase   <= PH_IDLE;
        clk_low <= 1'b0;
        dat_low <= 1'b0;
      end else begin
        case (phase)
          PH_IDLE: if (start) begin
            frm     <= frm_new;
            bitn    <= '0;
            dat_low <= ~frm_new[0];
            phase   <= PH_HIGH;
          end
          PH_HIGH: if (half_tick) begin
            if (!clk_line_hi) begin
              frame_abort <= 1'b1;
              dat_low     <= 1'b0;
              phase       <= PH_IDLE;
            end else begin
              clk_low <= 1'b1;
              phase   <= PH_LOW;
            end
          end
          PH_LOW: if (half_tick) begin
            clk_low <= 1'b0;
            if (bitn == LAST_BIT) begin
              frame_done <= 1'b1;
              dat_low    <= 1'b0;
              phase      <= PH_IDLE;
            end else begin
              bitn    <= bitn + 1'b1;
              dat_low <= ~frm[bitn + 1'b1];
              phase   <= PH_HIGH;
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  // R4: data moves only while the clock line is released.
  a_r4_data_with_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dat_low) |-> !clk_low)
    else $error("data changed while clock held low");

  a_r7_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start))
    else $error("busy rose without start");

  a_r10_abort_releases: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |-> (!busy && !clk_low && !dat_low))
    else $error("abort left lines driven");

  a_r8_done_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (!frame_abort && $past(clk_low)))
    else $error("done without a final clock pulse");
endmodule

// File: rtl/ps2_dev_tx.sv
module ps2_dev_tx #(
  parameter int WORDS       = 4,
  parameter int HALF_CYC    = 4000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [2:0]                    wr_sel,
  input  logic [31:0]                   wr_data,
  input  logic                          ps2_clk_in,
  input  logic                          ps2_dat_in,
  output logic                          ps2_clk_oe,
  output logic                          ps2_dat_oe,
  output logic                          tx_busy,
  output logic                          tx_empty,
  output logic [$clog2(WORDS*4)-1:0]    tx_byte_idx,
  output logic                          tx_done_flag,
  output logic                          tx_irq
);
  localparam int BYTES   = WORDS * 4;
  localparam int IDX_W   = $clog2(BYTES);
  localparam int WSEL_W  = $clog2(WORDS);
  localparam int DEP_LSB = 2;
  localparam int CLR_BIT = DEP_LSB + IDX_W;
  localparam logic [2:0] SEL_CTRL = 3'(WORDS);
  localparam logic [2:0] SEL_ACK  = 3'(WORDS + 1);

  logic             en_r, ien_r, empty_r, flag_r;
  logic [IDX_W-1:0] depth_r, idx_r;

  // Named events for the assertions.
  logic       wr_word, wr_ctrl, wr_ack, clear_cmd, last_byte, start;
  logic       clk_hi, dat_hi;
  logic       frame_done, frame_abort;
  logic [7:0] cur_byte;

  assign wr_word   = wr_en && (wr_sel < SEL_CTRL);
  assign wr_ctrl   = wr_en && (wr_sel == SEL_CTRL);
  assign wr_ack    = wr_en && (wr_sel == SEL_ACK);
  assign clear_cmd = wr_ctrl && wr_data[CLR_BIT];
  assign last_byte = (idx_r == depth_r);

  ps2tx_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
    .clk(clk), .rst_n(rst_n), .d(ps2_clk_in), .q(clk_hi)
  );
  ps2tx_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
    .clk(clk), .rst_n(rst_n), .d(ps2_dat_in), .q(dat_hi)
  );

  ps2tx_buf #(.WORDS(WORDS)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_word(wr_word),
    .wr_word_sel(wr_sel[WSEL_W-1:0]), .wr_data(wr_data),
    .rd_idx(idx_r), .rd_byte(cur_byte)
  );

  assign start = !tx_busy && en_r && !empty_r && clk_hi && dat_hi
                 && !frame_done && !clear_cmd;

  ps2tx_frame #(.HALF_CYC(HALF_CYC)) u_frame (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_in(cur_byte),
    .kill(clear_cmd), .clk_line_hi(clk_hi),
    .clk_low(ps2_clk_oe), .dat_low(ps2_dat_oe), .busy(tx_busy),
    .frame_done(frame_done), .frame_abort(frame_abort)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_r    <= 1'b0;
      ien_r   <= 1'b0;
      depth_r <= '0;
    end else if (wr_ctrl) begin
      en_r    <= wr_data[0];
      ien_r   <= wr_data[1];
      depth_r <= wr_data[DEP_LSB +: IDX_W];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      empty_r <= 1'b1;
      idx_r   <= '0;
    end else if (clear_cmd) begin
      empty_r <= 1'b1;
      idx_r   <= '0;
    end else if (frame_done) begin
      if (last_byte) begin
        empty_r <= 1'b1;
        idx_r   <= '0;
      end else begin
        idx_r   <= idx_r + 1'b1;
      end
    end else if (wr_word && en_r) begin
      empty_r <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     flag_r <= 1'b0;
    else if (frame_done)            flag_r <= 1'b1;
    else if (wr_ack && wr_data[0])  flag_r <= 1'b0;

  assign tx_empty     = empty_r;
  assign tx_byte_idx  = idx_r;
  assign tx_done_flag = flag_r;
  assign tx_irq       = flag_r & ien_r;

  a_r6_idx_within_depth: assert property (@(posedge clk) disable iff (!rst_n)
    idx_r <= depth_r)
    else $error("byte index beyond depth");

  a_r6_empty_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(empty_r) |-> ($past(clear_cmd) || $past(frame_done && last_byte)))
    else $error("empty set without end or clear");

  a_r9_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
    clear_cmd |=> (!tx_busy && !ps2_clk_oe && !ps2_dat_oe && idx_r == '0 && empty_r))
    else $error("clear did not stop the engine");

  a_r8_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_r) |-> $past(frame_done))
    else $error("done flag set without a stop bit");

  a_r10_abort_keeps_idx: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_abort && !clear_cmd) |=> $stable(idx_r))
    else $error("abort moved the byte index");
endmodule

// File: tb/tb_ps2_dev_tx.sv
module tb_ps2_dev_tx;
  localparam int HALF = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        host_clk_hold = 1'b0;
  logic        host_dat_hold = 1'b0;
  wire         clk_oe, dat_oe, busy, empty, flag, irq;
  wire  [3:0]  idx;
  wire         clk_line = !clk_oe && !host_clk_hold;
  wire         dat_line = !dat_oe && !host_dat_hold;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ps2_dev_tx #(.WORDS(4), .HALF_CYC(HALF), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ps2_clk_in(clk_line), .ps2_dat_in(dat_line),
    .ps2_clk_oe(clk_oe), .ps2_dat_oe(dat_oe), .tx_busy(busy), .tx_empty(empty),
    .tx_byte_idx(idx), .tx_done_flag(flag), .tx_irq(irq)
  );

  // Bus monitor: the host samples data when the device pulls the clock low.
  int unsigned   cyc = 0;
  int unsigned   rise_c = 0, fall_c = 0, low_w = 0, high_w = 0;
  int            nb = 0;
  logic [10:0]   cap = '0;
  logic [10:0]   rx_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk_oe) begin
    if (nb > 0) high_w = cyc - fall_c;
    rise_c = cyc;
    cap = {dat_line, cap[10:1]};
    nb = nb + 1;
    if (nb == 11) begin
      rx_q.push_back(cap);
      nb = 0;
    end
  end

  always @(negedge clk_oe) begin
    fall_c = cyc;
    low_w  = cyc - rise_c;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] ctrl(input logic en, input logic ien,
                                       input logic [3:0] dep, input logic clr);
    return {25'd0, clr, dep, ien, en};
  endfunction

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!busy && empty) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_frame(input string req, input logic [7:0] b);
    logic [10:0] f;
    logic [10:0] exp;
    exp = {1'b1, ~(^b), b, 1'b0};
    if (rx_q.size() == 0) begin
      chk(req, "frame present", 32'd0, 32'd1);
    end else begin
      f = rx_q.pop_front();
      chk(req, "frame bits", {21'd0, f}, {21'd0, exp});
    end
  endtask

  task automatic t_reset();
    chk("R1", "clk_oe", clk_oe, 0);
    chk("R1", "dat_oe", dat_oe, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "empty", empty, 1);
    chk("R1", "idx", idx, 0);
    chk("R1", "flag", flag, 0);
    chk("R1", "irq", irq, 0);
  endtask

  task automatic t_disabled_write();
    wr(3'd0, 32'h4433_2211);
    repeat (100) @(negedge clk);
    chk("R3", "empty after disabled write", empty, 1);
    chk("R3", "no frame when disabled", rx_q.size(), 0);
  endtask

  task automatic t_burst4();
    wr(3'd4, ctrl(1, 0, 4'd3, 0));                  // R2 control decode
    wr(3'd0, 32'h4433_2211);
    chk("R3", "empty cleared by write", empty, 0);
    wr(3'd1, 32'h0); wr(3'd2, 32'h0); wr(3'd3, 32'h0);
    chk("R7", "busy during frame", busy, 1);
    wait_idle();
    expect_frame("R5", 8'h11);
    expect_frame("R5", 8'h22);
    expect_frame("R4", 8'h33);
    expect_frame("R4", 8'h44);
    chk("R6", "exactly four frames", rx_q.size(), 0);
    chk("R4", "clock low width", low_w, HALF);
    chk("R4", "clock high width", high_w, HALF);
    chk("R6", "empty after last", empty, 1);
    chk("R6", "idx after last", idx, 0);
    chk("R7", "busy after last", busy, 0);
    chk("R8", "flag set", flag, 1);
    chk("R8", "irq gated off", irq, 0);
  endtask

  task automatic t_irq();
    wr(3'd4, ctrl(1, 1, 4'd3, 0));
    chk("R8", "irq with enable", irq, 1);
    wr(3'd5, 32'h0);
    chk("R8", "write 0 keeps flag", flag, 1);
    wr(3'd5, 32'h1);
    chk("R8", "flag cleared", flag, 0);
    chk("R8", "irq cleared", irq, 0);
  endtask

  task automatic t_full16();
    wr(3'd4, ctrl(1, 0, 4'd15, 0));
    wr(3'd0, 32'h0302_0100);
    wr(3'd1, 32'h1312_1110);
    wr(3'd2, 32'h2322_2120);
    wr(3'd3, 32'hF3E2_D1C0);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (flag) break;
    end
    chk("R6", "idx after first frame", idx, 1);
    wait_idle();
    for (int w = 0; w < 4; w++)
      for (int l = 0; l < 4; l++) begin
        logic [7:0] b;
        b = (w == 3) ? 8'(32'hF3E2_D1C0 >> (8 * l)) : 8'((w << 4) | l);
        expect_frame("R5", b);
      end
    chk("R6", "sixteen frames only", rx_q.size(), 0);
    wr(3'd5, 32'h1);
  endtask

  task automatic t_single();
    wr(3'd4, ctrl(1, 0, 4'd0, 0));
    wr(3'd0, 32'hFFFF_FFA5);
    wait_idle();
    expect_frame("R6", 8'hA5);
    chk("R6", "one frame for depth 0", rx_q.size(), 0);
    wr(3'd5, 32'h1);
  endtask

  task automatic t_clear();
    wr(3'd4, ctrl(1, 0, 4'd3, 0));
    wr(3'd0, 32'h8765_4321);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (flag) break;
    end
    repeat (50) @(negedge clk);
    wr(3'd4, ctrl(1, 0, 4'd3, 1));
    chk("R9", "busy after clear", busy, 0);
    chk("R9", "clk released", clk_oe, 0);
    chk("R9", "dat released", dat_oe, 0);
    chk("R9", "empty after clear", empty, 1);
    chk("R9", "idx after clear", idx, 0);
    nb = 0;
    expect_frame("R9", 8'h21);
    chk("R9", "partial frame dropped", rx_q.size(), 0);
    wr(3'd5, 32'h1);
    wr(3'd3, 32'h0);               // restart from index 0, old word 0 kept
    wait_idle();
    expect_frame("R9", 8'h21);
    expect_frame("R9", 8'h43);
    expect_frame("R9", 8'h65);
    expect_frame("R9", 8'h87);
    wr(3'd5, 32'h1);
  endtask

  task automatic t_dat_held();
    wr(3'd4, ctrl(1, 0, 4'd0, 0));
    host_dat_hold = 1'b1;
    wr(3'd0, 32'h0000_0066);
    repeat (100) @(negedge clk);
    chk("R3", "no start with data low", busy, 0);
    chk("R3", "still pending", empty, 0);
    host_dat_hold = 1'b0;
    wait_idle();
    expect_frame("R3", 8'h66);
    wr(3'd5, 32'h1);
  endtask

  task automatic t_inhibit();
    wr(3'd4, ctrl(1, 0, 4'd1, 0));
    wr(3'd0, 32'h0000_5A3C);
    for (int k = 0; k < 3; k++) @(posedge clk_oe);
    @(negedge clk_oe);
    repeat (2) @(negedge clk);
    host_clk_hold = 1'b1;
    repeat (40) @(negedge clk);
    chk("R10", "busy after inhibit", busy, 0);
    chk("R10", "idx kept", idx, 0);
    chk("R10", "clk released", clk_oe, 0);
    chk("R10", "dat released", dat_oe, 0);
    nb = 0;
    host_clk_hold = 1'b0;
    wait_idle();
    expect_frame("R10", 8'h3C);
    expect_frame("R10", 8'h5A);
    chk("R10", "no extra frames", rx_q.size(), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_disabled_write();
    t_burst4();
    t_irq();
    t_full16();
    t_single();
    t_clear();
    t_dat_held();
    t_inhibit();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule